// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Master

This block is a master-only serial peripheral shift engine for one byte at a time. Software reaches it through a small register port: a single address bit selects either a control-and-status byte or a data byte. Writing the data byte while the engine is idle loads it and starts a transfer. The engine then produces the serial clock by dividing the system clock, shifts the loaded byte out on one pin and assembles a byte from the input pin.

The control byte sets the resting level of the serial clock, the clock edge on which input is sampled, the bit order and whether the pins are driven. It also holds two flags that only hardware can set: one for a data write that arrived while a transfer was running, and one for a finished byte. The finished flag also drives an interrupt request. Reading the data address returns the most recently received byte.

The register port has no back-pressure. A write is taken in the cycle in which it appears, and a read returns data combinationally in the same cycle. A data write that finds the engine busy is dropped, and only the collision flag records it. The pins are reported through output-enable outputs so that a pad ring can tri-state them.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, both read addresses return 0, the busy and interrupt outputs are 0, and the serial clock rests high.
- R2: `bus_addr`=0 selects the control byte and `bus_addr`=1 selects the data byte. Control bit layout: [5] clock polarity, [4] capture-edge select, [3] bit order, [2] pin enable, [1] collision flag, [0] done flag. Bits 7 and 6 always read 0.
- R3: When no transfer is running, the serial clock rests high with polarity 0 and low with polarity 1.
- R4: Input is sampled on the rising edge for (polarity, edge) = (0,0) and (1,1), and on the falling edge for (0,1) and (1,0). The output bit changes only on the opposite edge, and the first output bit is valid from the start of the transfer.
- R5: With bit order 1 the most significant bit goes out first, and with 0 the least significant bit goes out first. Received bits are placed in the same order, so the data read after a transfer equals the byte the slave sent.
- R6: Each half period of the serial clock lasts DIV+1 system clocks, and a byte takes 16 clock edges. Busy rises in the cycle after the accepted data write and falls on the 16th edge.
- R7: Both output enables equal the pin-enable bit. A transfer still runs when the pins are released.
- R8: A data write while busy does not change the byte being sent, and it sets the collision flag.
- R9: The done flag is set on the same clock as busy falls, and the interrupt output equals the done flag.
- R10: Software clears either flag by writing 0 to its bit, and writing 1 to it has no effect. A hardware set in the same cycle as a software clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Interrupt request (done flag) |

## Verification
The bench runs all eight combinations of polarity, capture edge and bit order against a slave model. The slave changes its bit on the edge the master does not sample. If the capture edge were swapped, the received byte would come back shifted by one bit or mis-ordered. It drives a second data write into the middle of a transfer, where a design that accepts it would corrupt the output bit stream or fail to raise the collision flag. It times a software flag clear to land on the exact cycle of completion, which a design that gives the clear priority would lose. It also checks that writing 1 to a flag never sets it, and that released pins do not stop the shifting.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int unsigned F_POL   = 5;
  localparam int unsigned F_EDGE  = 4;
  localparam int unsigned F_ORDER = 3;
  localparam int unsigned F_EN    = 2;
  localparam int unsigned F_WCOL  = 1;
  localparam int unsigned F_DONE  = 0;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef struct packed {
    logic pol;
    logic lead_capture;
    logic msb_first;
    logic pin_en;
  } spi_mode_t;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int unsigned DIV   = 1,
  parameter int unsigned EDGES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     idle_lvl_i,
  output logic                     busy_o,
  output logic                     sclk_o,
  output logic                     tick_o,
  output logic [$clog2(EDGES)-1:0] edge_idx_o,
  output logic                     last_o
);
  localparam int unsigned DW = (DIV > 0) ? $clog2(DIV + 1) : 1;
  localparam int unsigned EW = $clog2(EDGES);

  logic [DW-1:0] div_cnt;
  logic [EW-1:0] edge_cnt;
  logic          toggled;
  logic          running;

  assign tick_o     = running && (div_cnt == DW'(DIV));
  assign last_o     = (edge_cnt == EW'(EDGES - 1));
  assign edge_idx_o = edge_cnt;
  assign busy_o     = running;
  assign sclk_o     = idle_lvl_i ^ toggled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      toggled  <= 1'b0;
    end else if (start_i) begin
      running  <= 1'b1;
      div_cnt  <= '0;
      edge_cnt <= '0;
      toggled  <= 1'b0;
    end else if (running) begin
      if (tick_o) begin
        div_cnt  <= '0;
        toggled  <= ~toggled;
        edge_cnt <= edge_cnt + 1'b1;
        if (last_o) running <= 1'b0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         msb_first_i,
  input  logic         lead_capture_i,
  input  logic         tick_i,
  input  logic         lead_i,
  input  logic         first_i,
  input  logic         last_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_next_o
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;
  logic         capture;
  logic         shift;

  assign capture = tick_i && (lead_capture_i ? lead_i : !lead_i);
  assign shift   = tick_i && (lead_capture_i ? (!lead_i && !last_i)
                                             : (lead_i && !first_i));

  always_comb begin
    rx_next_o = rx_q;
    if (capture) begin
      if (msb_first_i) rx_next_o = {rx_q[W-2:0], miso_i};
      else             rx_next_o = {miso_i, rx_q[W-1:1]};
    end
  end

  assign mosi_o = msb_first_i ? tx_q[W-1] : tx_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      rx_q <= rx_next_o;
      if (load_i) begin
        tx_q <= load_data_i;
      end else if (shift) begin
        if (msb_first_i) tx_q <= {tx_q[W-2:0], 1'b0};
        else             tx_q <= {1'b0, tx_q[W-1:1]};
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
#(
  parameter int unsigned DIV    = 1,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned EW    = $clog2(EDGES);

  spi_mode_t         mode;
  logic              wcol_q;
  logic              done_q;
  logic [DATA_W-1:0] rx_buf;

  logic              busy;
  logic              tick;
  logic              last;
  logic [EW-1:0]     edge_idx;
  logic [DATA_W-1:0] rx_next;
  logic              ctrl_wr, data_wr, start, collide, finish;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:6];

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign start   = data_wr && !busy;
  assign collide = data_wr && busy;
  assign finish  = tick && last;

  spi_sclk_gen #(.DIV(DIV), .EDGES(EDGES)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .idle_lvl_i (~mode.pol),
    .busy_o     (busy),
    .sclk_o     (sclk_o),
    .tick_o     (tick),
    .edge_idx_o (edge_idx),
    .last_o     (last)
  );

  spi_shift_unit #(.W(DATA_W)) u_shift (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_i         (start),
    .load_data_i    (bus_wdata),
    .msb_first_i    (mode.msb_first),
    .lead_capture_i (mode.lead_capture),
    .tick_i         (tick),
    .lead_i         (~edge_idx[0]),
    .first_i        (edge_idx == '0),
    .last_i         (last),
    .miso_i         (miso_i),
    .mosi_o         (mosi_o),
    .rx_next_o      (rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      wcol_q <= 1'b0;
      done_q <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) begin
        mode.pol          <= bus_wdata[F_POL];
        mode.lead_capture <= bus_wdata[F_EDGE];
        mode.msb_first    <= bus_wdata[F_ORDER];
        mode.pin_en       <= bus_wdata[F_EN];
      end
      if (collide)                            wcol_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[F_WCOL]) wcol_q <= 1'b0;
      if (finish)                             done_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[F_DONE]) done_q <= 1'b0;
      if (finish) rx_buf <= rx_next;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_DATA) begin
      bus_rdata = rx_buf;
    end else begin
      bus_rdata[F_POL]   = mode.pol;
      bus_rdata[F_EDGE]  = mode.lead_capture;
      bus_rdata[F_ORDER] = mode.msb_first;
      bus_rdata[F_EN]    = mode.pin_en;
      bus_rdata[F_WCOL]  = wcol_q;
      bus_rdata[F_DONE]  = done_q;
    end
  end

  assign sclk_oe = mode.pin_en;
  assign mosi_oe = mode.pin_en;
  assign busy_o  = busy;
  assign irq_o   = done_q;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sclk_o,
  input logic              sclk_oe,
  input logic              mosi_oe,
  input logic              busy_o,
  input logic              irq_o,
  input logic              pol_i
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> bus_rdata[DATA_W-1:6] == '0); // R2

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o == !pol_i); // R3

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && !busy_o) |=> busy_o); // R6

  AST_PIN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr) |=> (sclk_oe == $past(bus_wdata[2])) && (mosi_oe == $past(bus_wdata[2]))); // R7

  AST_COLLISION_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && busy_o) |=> bus_rdata[1] || bus_addr); // R8

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> irq_o); // R9

  AST_STICKY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(bus_wr && !bus_addr && !bus_wdata[0])) |=> irq_o); // R10
endmodule

bind spi_byte_master spi_byte_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sclk_o    (sclk_o),
  .sclk_oe   (sclk_oe),
  .mosi_oe   (mosi_oe),
  .busy_o    (busy_o),
  .irq_o     (irq_o),
  .pol_i     (mode.pol)
);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int H          = DIV + 1;
  localparam int EDGES      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_i, busy_o, irq_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  int         t;
  bit         m_busy, m_pol, m_edge, m_msb, m_en, m_wcol, m_done;
  logic [7:0] m_tx, m_slave, m_rx, slave_next;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master #(.DIV(DIV), .DATA_W(8)) u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
    .busy_o(busy_o), .irq_o(irq_o)
  );

  // Number of bits already shifted after e clock edges.
  function automatic int bit_pos(int e, bit lead_cap);
    int s;
    if (lead_cap) s = e / 2;
    else          s = (e == 0) ? 0 : (e - 1) / 2;
    if (s > 7) s = 7;
    return s;
  endfunction

  function automatic logic pick(logic [7:0] b, bit msb, int s);
    return msb ? b[7 - s] : b[s];
  endfunction

  assign miso_i = m_busy ? pick(m_slave, m_msb, bit_pos(t / H, m_edge)) : 1'b0;

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t <= 0; m_busy <= 0; m_pol <= 0; m_edge <= 0; m_msb <= 0; m_en <= 0;
      m_wcol <= 0; m_done <= 0; m_tx <= 0; m_slave <= 0; m_rx <= 0;
    end else begin
      if (m_busy) begin
        if (t + 1 == EDGES * H) begin
          m_busy <= 0; m_done <= 1; m_rx <= m_slave;
        end
        t <= t + 1;
      end
      if (bus_wr && !bus_addr) begin
        m_pol <= bus_wdata[5]; m_edge <= bus_wdata[4];
        m_msb <= bus_wdata[3]; m_en <= bus_wdata[2];
        if (!bus_wdata[1]) m_wcol <= 0;
        if (!bus_wdata[0] && !(m_busy && t + 1 == EDGES * H)) m_done <= 0;
      end
      if (bus_wr && bus_addr) begin
        if (m_busy) m_wcol <= 1;
        else begin
          m_busy <= 1; t <= 0; m_tx <= bus_wdata; m_slave <= slave_next;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic idle;
      int   e;
      idle = !m_pol;
      e = t / H;
      if (!m_busy) chk("R3 idle clock level", sclk_o, idle);
      else begin
        chk("R6 clock edge timing", sclk_o, idle ^ e[0]);
        chk("R4 mosi bit", mosi_o, pick(m_tx, m_msb, bit_pos(e, m_edge)));
      end
      chk("R7 output enables", {sclk_oe, mosi_oe}, {m_en, m_en});
      chk("R6 busy", busy_o, m_busy);
      chk("R9 irq", irq_o, m_done);
      chk("R2 read data", bus_rdata,
          bus_addr ? m_rx : {2'b00, m_pol, m_edge, m_msb, m_en, m_wcol, m_done});
    end
  end

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic set_addr(input logic a);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_busy) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog actual=busy expected=idle");
      finish_run();
    end
  end

  initial begin
    slave_next = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 control read", bus_rdata, 8'h00);
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 clock rests high", sclk_o, 1'b1);
    set_addr(1'b1);
    chk("R1 data read", bus_rdata, 8'h00);

    // R4 R5: all polarity / edge / order modes
    for (int m = 0; m < 8; m++) begin
      bus_write(1'b0, {2'b00, m[2], m[1], m[0], 1'b1, 2'b00});
      slave_next = 8'h5A ^ 8'(m * 37);
      bus_write(1'b1, 8'hC3 ^ 8'(m * 17));
      wait_idle();
      chk("R5 received byte", bus_rdata, 8'h5A ^ 8'(m * 37));
      chk("R9 done after byte", irq_o, 1'b1);
      bus_write(1'b0, {2'b00, m[2], m[1], m[0], 1'b1, 2'b00});
      @(negedge clk);
      chk("R10 done cleared by 0", irq_o, 1'b0);
    end

    // R8 collision
    bus_write(1'b0, 8'b0000_1100);
    slave_next = 8'hA7;
    bus_write(1'b1, 8'h3C);
    repeat (10) @(posedge clk);
    bus_write(1'b1, 8'hFF);
    set_addr(1'b0);
    chk("R8 collision flag set", bus_rdata[1], 1'b1);
    wait_idle();
    set_addr(1'b1);
    chk("R8 dropped write, rx intact", bus_rdata, 8'hA7);

    // R10 writing 1 to flags has no effect, writing 0 clears
    bus_write(1'b0, 8'b0000_1111);
    @(negedge clk);
    chk("R10 flags kept on write 1", bus_rdata, 8'h0F);
    bus_write(1'b0, 8'b0000_1100);
    @(negedge clk);
    chk("R10 flags cleared", bus_rdata, 8'h0C);
    bus_write(1'b0, 8'b1100_1111);
    @(negedge clk);
    chk("R2 R10 no flag set, upper bits zero", bus_rdata, 8'h0C);

    // R10 set wins over same-cycle clear
    slave_next = 8'h81;
    bus_write(1'b1, 8'h18);
    repeat (EDGES * H - 1) @(posedge clk);
    #1 bus_wr = 1; bus_addr = 1'b0; bus_wdata = 8'b0000_1100;
    @(posedge clk); #1 bus_wr = 0;
    @(negedge clk);
    chk("R10 set beats clear", irq_o, 1'b1);
    bus_write(1'b0, 8'b0011_0000);

    // R7 pins released, transfer still runs
    slave_next = 8'h6E;
    bus_write(1'b1, 8'h91);
    repeat (5) @(negedge clk);
    chk("R7 pins released mid-transfer", {sclk_oe, mosi_oe}, 2'b00);
    chk("R3 clock low idle polarity 1 running", busy_o, 1'b1);
    wait_idle();
    set_addr(1'b1);
    chk("R7 transfer completes without pins", bus_rdata, 8'h6E);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule